// File: doc/BRIEF.md
# Exponent Bit Scanner with Implicit Leading One

This block feeds an exponentiation sequencer with the bits of an exponent, one bit per handshake, most significant first. The exponent sits in a word-addressed operand RAM with 32-bit words, least significant word at the lowest address. Software supplies a word address for that lowest word and a length field that holds the exponent length in bits minus two. The top bit of any exponent is a one by definition, so it is not stored. The block hands that bit out first without touching the RAM, then walks the stored bits from index `len` down to index 0.

A start pulse captures the address and length while the block is idle. The block reads a RAM word only when the scan enters it. The RAM answers one cycle after a request. Bits leave on a valid/ready stream, and a flag marks bit 0. One cycle after bit 0 is taken, the block raises a single-cycle done pulse and returns to idle.

Top module: `exp_bit_scanner`

## Requirements
- R1: While reset is held, and after reset until the first start, `bit_valid_o`, `rd_req_o` and `done_o` are all 0.
- R2: A start sampled while idle makes the first output bit available in the next cycle. This bit always has value 1, and no RAM read is issued for it.
- R3: After the leading one, exactly `len_i+1` more bits are emitted, for indices `len_i` down to 0 in that order. The bit for index i is bit `i % 32` of the word at address `base_i + i/32`. A full exponent is therefore `len_i+2` bits long.
- R4: Exactly `len_i/32 + 1` reads are issued per scan, one each time the scan enters a new word. Each read is a single-cycle `rd_req_o`, and its addresses descend from `base_i + len_i/32` to `base_i`.
- R5: Read data is taken in the cycle after the request. No bit is offered in that cycle. With ready held high, done rises `2*(len_i/32+1) + len_i + 3` cycles after the start is sampled.
- R6: `bit_last_o` is 1 only while the bit for index 0 is offered, and it is 0 for the leading one.
- R7: While `bit_valid_o` is high and `bit_ready_i` is low, the offered bit, its last flag and its valid stay unchanged in the next cycle.
- R8: `done_o` is a one-cycle pulse in the cycle after the last bit is accepted, and it is high at no other time.
- R9: A start pulse during an active scan is ignored, together with its address and length, and the running scan's output is unchanged.
- R10: With `len_i = 0`, the scan emits exactly two bits (the leading one, then stored bit 0) and issues one read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| base_i | input | 11 | Word address of the exponent's least significant word (even) |
| len_i | input | 13 | Exponent bit length minus two (below 4159) |
| rd_req_o | output | 1 | RAM read request, one cycle |
| rd_addr_o | output | 11 | RAM read word address |
| rd_data_i | input | 32 | RAM read data, valid the cycle after the request |
| bit_valid_o | output | 1 | An exponent bit is offered |
| bit_o | output | 1 | Offered exponent bit value |
| bit_last_o | output | 1 | Offered bit is bit 0 |
| bit_ready_i | input | 1 | Consumer accepts the offered bit |
| done_o | output | 1 | One-cycle pulse after bit 0 is accepted |

## Verification
The leading one is due one cycle after the start is sampled. Each word's first stored bit comes three cycles after the bit before it is accepted: one cycle for the request, one for the returned data and one to present the bit. Within a word, the next bit follows one cycle after each acceptance. Done follows the accepted last bit by one cycle. The bench drives inputs on falling edges and samples on the next falling edge, tracking a model index that moves only on observed acceptances. It also checks the done arrival cycle against the closed-form count of R5 whenever ready is held high.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_FETCH = 3'd2,
    ST_WAIT  = 3'd3,
    ST_EMIT  = 3'd4
  } scan_state_e;
endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic ready_i,
  input  logic idx_zero_i,
  input  logic idx_low_zero_i,
  output logic load_en_o,
  output logic dec_en_o,
  output logic cap_en_o,
  output logic rd_req_o,
  output logic valid_o,
  output logic lead_o,
  output logic busy_o,
  output logic done_o
);
  scan_state_e state_q, state_d;
  logic        done_q, done_d;

  always_comb begin
    state_d   = state_q;
    done_d    = 1'b0;
    load_en_o = 1'b0;
    dec_en_o  = 1'b0;
    cap_en_o  = 1'b0;
    rd_req_o  = 1'b0;
    valid_o   = 1'b0;
    lead_o    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          load_en_o = 1'b1;
          state_d   = ST_LEAD;
        end
      end
      ST_LEAD: begin
        valid_o = 1'b1;
        lead_o  = 1'b1;
        if (ready_i) state_d = ST_FETCH;
      end
      ST_FETCH: begin
        rd_req_o = 1'b1;
        state_d  = ST_WAIT;
      end
      ST_WAIT: begin
        cap_en_o = 1'b1;
        state_d  = ST_EMIT;
      end
      ST_EMIT: begin
        valid_o = 1'b1;
        if (ready_i) begin
          if (idx_zero_i) begin
            done_d  = 1'b1;
            state_d = ST_IDLE;
          end else begin
            dec_en_o = 1'b1;
            if (idx_low_zero_i) state_d = ST_FETCH;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q != ST_IDLE);
  assign done_o = done_q;

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !rd_req_o); // R4
  AST_NO_BIT_ON_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |=> !valid_o); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R8
endmodule

// File: rtl/scan_index.sv
module scan_index #(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en_i,
  input  logic              dec_en_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [$clog2(DATA_W)-1:0] bit_sel_o,
  output logic              idx_zero_o,
  output logic              idx_low_zero_o
);
  localparam int LSB_W = $clog2(DATA_W);

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  idx_q, idx_d;
  logic [CNT_W-LSB_W-1:0] word_off;

  always_comb begin
    idx_d = idx_q;
    if (load_en_i)     idx_d = len_i;
    else if (dec_en_i) idx_d = idx_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      idx_q  <= '0;
    end else begin
      if (load_en_i) base_q <= base_i;
      if (load_en_i || dec_en_i) idx_q <= idx_d;
    end
  end

  assign word_off       = idx_q[CNT_W-1:LSB_W];
  assign addr_o         = base_q + ADDR_W'(word_off);
  assign bit_sel_o      = idx_q[LSB_W-1:0];
  assign idx_zero_o     = (idx_q == '0);
  assign idx_low_zero_o = (idx_q[LSB_W-1:0] == '0);

  AST_NO_DEC_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    dec_en_i |-> !idx_zero_o); // R3
endmodule

// File: rtl/scan_word.sv
module scan_word #(
  parameter int DATA_W = 32
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cap_en_i,
  input  logic [DATA_W-1:0]         data_i,
  input  logic [$clog2(DATA_W)-1:0] sel_i,
  output logic                      bit_o
);
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word_q <= '0;
    else if (cap_en_i) word_q <= data_i;
  end

  assign bit_o = word_q[sel_i];
endmodule

// File: rtl/exp_bit_scanner.sv
module exp_bit_scanner #(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 13,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [CNT_W-1:0]  len_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              bit_valid_o,
  output logic              bit_o,
  output logic              bit_last_o,
  input  logic              bit_ready_i,
  output logic              done_o
);
  localparam int LSB_W = $clog2(DATA_W);

  logic load_en, dec_en, cap_en, lead, busy;
  logic idx_zero, idx_low_zero, word_bit;
  logic [LSB_W-1:0] bit_sel;

  scan_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .start_i       (start_i),
    .ready_i       (bit_ready_i),
    .idx_zero_i    (idx_zero),
    .idx_low_zero_i(idx_low_zero),
    .load_en_o     (load_en),
    .dec_en_o      (dec_en),
    .cap_en_o      (cap_en),
    .rd_req_o      (rd_req_o),
    .valid_o       (bit_valid_o),
    .lead_o        (lead),
    .busy_o        (busy),
    .done_o        (done_o)
  );

  scan_index #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DATA_W(DATA_W)) u_index (
    .clk           (clk),
    .rst_n         (rst_n),
    .load_en_i     (load_en),
    .dec_en_i      (dec_en),
    .base_i        (base_i),
    .len_i         (len_i),
    .addr_o        (rd_addr_o),
    .bit_sel_o     (bit_sel),
    .idx_zero_o    (idx_zero),
    .idx_low_zero_o(idx_low_zero)
  );

  scan_word #(.DATA_W(DATA_W)) u_word (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_en_i(cap_en),
    .data_i  (rd_data_i),
    .sel_i   (bit_sel),
    .bit_o   (word_bit)
  );

  assign bit_o      = lead | word_bit;
  assign bit_last_o = bit_valid_o & ~lead & idx_zero;

  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_valid_o && !bit_ready_i) |=> (bit_valid_o && $stable(bit_o) && $stable(bit_last_o))); // R7
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(bit_valid_o && bit_ready_i && bit_last_o)); // R8
  AST_IGNORE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start_i) |=> $stable(u_index.base_q)); // R9
  AST_LEAD_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start_i) |=> (bit_valid_o && bit_o && !rd_req_o)); // R2
endmodule

// File: tb/exp_bit_scanner_tb.sv
module exp_bit_scanner_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [10:0] base_i;
  logic [12:0] len_i;
  logic        rd_req_o;
  logic [10:0] rd_addr_o;
  logic [31:0] rd_data_i;
  logic        bit_valid_o, bit_o, bit_last_o, bit_ready_i, done_o;

  int total = 0;
  int bad   = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2.5 clk = ~clk;

  exp_bit_scanner u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .len_i(len_i),
    .rd_req_o(rd_req_o), .rd_addr_o(rd_addr_o), .rd_data_i(rd_data_i),
    .bit_valid_o(bit_valid_o), .bit_o(bit_o), .bit_last_o(bit_last_o),
    .bit_ready_i(bit_ready_i), .done_o(done_o)
  );

  function automatic logic [31:0] mem_word(input int a);
    logic [31:0] v;
    v = 32'(a) * 32'h9E3779B1;
    return v ^ (32'(a) << 7) ^ 32'h5A5A0F0F;
  endfunction

  always_ff @(posedge clk) begin
    if (rd_req_o) rd_data_i <= mem_word(int'(rd_addr_o));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_scan(input int base, input int len, input bit rnd_ready, input bit inject);
    int  nidx, reads, cyc, words;
    bit  stalled, pbit, plast, fin;
    nidx    = len + 1;
    reads   = 0;
    cyc     = 0;
    words   = (len >> 5) + 1;
    stalled = 1'b0;
    pbit    = 1'b0;
    plast   = 1'b0;
    fin     = 1'b0;
    start_i = 1'b1;
    base_i  = 11'(base);
    len_i   = 13'(len);
    @(negedge clk);
    start_i = 1'b0;
    while (!fin) begin
      cyc++;
      if (inject) begin
        start_i = (cyc == 3 || cyc == 9);
        base_i  = 11'(base + 40);
        len_i   = 13'(len / 2);
      end
      if (rd_req_o) begin
        chk(int'(rd_addr_o) == base + (words - 1 - reads), "R4 read address",
            int'(rd_addr_o), base + (words - 1 - reads));
        reads++;
      end
      if (stalled)
        chk(bit_valid_o && bit_o == pbit && bit_last_o == plast, "R7 hold under stall",
            int'(bit_o), int'(pbit));
      if (done_o) begin
        chk(nidx == -1, "R8 done after last", nidx, -1);
        if (!rnd_ready)
          chk(cyc == 2 * words + len + 3, "R5 done latency", cyc, 2 * words + len + 3);
        fin = 1'b1;
      end else if (bit_valid_o) begin
        if (nidx == len + 1) begin
          chk(bit_o == 1'b1 && reads == 0, "R2 implicit leading one", int'(bit_o), 1);
          if (!stalled) chk(cyc == 1, "R2 leading one timing", cyc, 1);
        end else begin
          logic eb;
          eb = mem_word(base + (nidx >> 5))[nidx % 32];
          chk(bit_o == eb, len == 0 ? "R10 stored bit" : "R3 stored bit", int'(bit_o), int'(eb));
        end
        chk(bit_last_o == (nidx == 0), "R6 last flag", int'(bit_last_o), int'(nidx == 0));
      end
      if (cyc > 20000) begin
        chk(1'b0, "watchdog", cyc, 0);
        fin = 1'b1;
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      bit_ready_i = rnd_ready ? lfsr[0] : 1'b1;
      stalled = bit_valid_o && !bit_ready_i;
      pbit    = bit_o;
      plast   = bit_last_o;
      if (bit_valid_o && bit_ready_i) nidx--;
      if (!fin) @(negedge clk);
    end
    start_i = 1'b0;
    chk(reads == words, len == 0 ? "R10 read count" : "R4 read count", reads, words);
    @(negedge clk);
    chk(!done_o && !bit_valid_o, "R8 done single pulse", int'(done_o), 0);
    if (inject) chk(nidx == -1, "R9 ignored start kept scan", nidx, -1);
  endtask

  initial begin
    #5000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    start_i = 1'b0;
    base_i = '0;
    len_i = '0;
    bit_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    chk(!bit_valid_o && !rd_req_o && !done_o, "R1 reset outputs", int'(bit_valid_o), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!bit_valid_o && !rd_req_o && !done_o, "R1 idle after reset", int'(rd_req_o), 0);
    for (int l = 0; l < 100; l++) run_scan((l * 6) % 1800, l, l[0], 1'b0);
    run_scan(0, 0, 1'b1, 1'b0);
    run_scan(1000, 70, 1'b0, 1'b1);
    run_scan(200, 130, 1'b1, 1'b1);
    run_scan(0, 4158, 1'b1, 1'b0);
    run_scan(1900, 4158, 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule